// File: doc/BRIEF.md
# Strobe-Driven FIFO Buffer with Flow-Through

This block is a first-in first-out buffer for 9-bit words. Its write and read strobes are active-low level signals, not clocks. A single system clock samples both strobes. The block compares each strobe with its value from the previous cycle to find the strobe edges. Read and write pointers are one bit wider than the address. From them the block derives active-low empty and full flags. The read side models a three-state bus as a data word plus an output-enable bit. While the enable is low, the data port reads as zero.

A write stores one word for each low period of the write strobe. A read presents one word for each low period of the read strobe. The block also resolves two corner cases where one strobe is already held low when the opposite operation changes the occupancy:

- **Read flow-through:** a held read strobe picks up the first word written into an empty buffer, with no new falling edge on the read strobe.
- **Write flow-through:** a held write strobe places its pending word in the slot that a read frees in a full buffer.

Capacity is set by the address width. An address width of 14 gives the full 16384-word configuration. The default is smaller so that elaboration stays light.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is active, and just after it is released, `empty_no` is 0, `full_no` is 1 and `oe_o` is 0.
- R2: A write strobe that goes low while the buffer is not full stores `data_i` in the cycle it is first seen low. Exactly one word is stored for each low period of the strobe.
- R3: A write strobe that goes low while the buffer is full, and is released before any read takes place, stores nothing and leaves `full_no` at 0.
- R4: A read strobe that goes low while the buffer is not empty drives the oldest word onto `data_o`, with `oe_o` at 1, one cycle after the strobe is first seen low. The word stays stable while the strobe is held low. `oe_o` returns to 0 one cycle after the strobe is seen high.
- R5: A read strobe held low while the buffer is empty keeps `oe_o` at 0. If that strobe is released before any write, a later write does not raise `oe_o`.
- R6: Successive reads return the words in the order they were written.
- R7: Read flow-through. The read strobe is held low on an empty buffer, and a write then occurs. `empty_no` reads 1 for exactly one cycle. In the next cycle the written word appears on `data_o` with `oe_o` at 1, and `empty_no` returns to 0.
- R8: While the read strobe stays low after a word has been presented, further writes are accepted and drive `empty_no` to 1. `data_o` keeps the first word, and the read pointer does not advance.
- R9: After the read strobe rises, each later low period of the read strobe presents the next stored word.
- R10: Write flow-through. The write strobe is held low on a full buffer, and a read then occurs. `full_no` reads 1 for exactly one cycle. The held word is then stored and `full_no` returns to 0. That word is read back last.
- R11: `full_no` is 0 exactly when 2^ADDR_W words are stored. The occupancy never exceeds that, and the two flags are never both active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples both strobes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_ni | input | 1 | Active-low write strobe |
| rd_ni | input | 1 | Active-low read strobe |
| data_i | input | DATA_W | Word to store |
| data_o | output | DATA_W | Word presented; zero while `oe_o` is 0 |
| oe_o | output | 1 | Output enable of the modelled three-state bus |
| empty_no | output | 1 | Active-low empty flag |
| full_no | output | 1 | Active-low full flag |

## Verification
The bound checker watches these properties on every cycle:
- the occupancy bound and the exclusion between the two flags;
- the write pointer moves only by one step and only after the write strobe was low;
- the output enable drops only after the read strobe was high, and rises only when the buffer was not empty;
- the presented word is stable, and the read pointer frozen, while a read strobe stays low.

Some behaviours only the directed scenarios can show. These are the one-cycle flag pulses of both flow-through cases, the word order across a full drain, and the discarding of a write attempted on a full buffer and then abandoned.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_SHOW = 1'b1
  } rd_state_t;
endpackage

// File: rtl/strobe_fifo_strobe.sv
// Edge detect plus an arm bit that keeps a request pending while the strobe stays low.
module strobe_fifo_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  input  logic take_i,
  output logic req_o
);
  logic strobe_q, arm_q, fall;

  assign fall  = strobe_q & ~strobe_ni;
  assign req_o = (fall | arm_q) & ~strobe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      arm_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_ni;
      arm_q    <= req_o & ~take_i;
    end
  end
endmodule

// File: rtl/strobe_fifo_ptrs.sv
module strobe_fifo_ptrs #(
  parameter int ADDR_W = 8,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_go_i,
  input  logic             rd_go_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             empty_o,
  output logic             full_o
);
  assign empty_o = (wr_ptr_o == rd_ptr_o);
  assign full_o  = (wr_ptr_o[ADDR_W] != rd_ptr_o[ADDR_W]) &&
                   (wr_ptr_o[ADDR_W-1:0] == rd_ptr_o[ADDR_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
    end else begin
      if (wr_go_i) wr_ptr_o <= wr_ptr_o + PTR_W'(1);
      if (rd_go_i) rd_ptr_o <= rd_ptr_o + PTR_W'(1);
    end
  end
endmodule

// File: rtl/strobe_fifo_mem.sv
module strobe_fifo_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o,
  output logic              empty_no,
  output logic              full_no
);
  localparam int PTR_W = ADDR_W + 1;

  logic             wr_req, rd_req, wr_go, rd_go, empty, full;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [DATA_W-1:0] rd_data, dout_q;
  rd_state_t        rd_state_q;

  strobe_fifo_strobe u_wr_strobe (
    .clk_i, .rst_ni, .strobe_ni(wr_ni), .take_i(wr_go), .req_o(wr_req)
  );

  strobe_fifo_strobe u_rd_strobe (
    .clk_i, .rst_ni, .strobe_ni(rd_ni), .take_i(rd_go), .req_o(rd_req)
  );

  // A pending request waits on the flag: this is what gives both flow-through modes.
  assign wr_go = wr_req & ~full;
  assign rd_go = rd_req & ~empty;

  strobe_fifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk_i, .rst_ni,
    .wr_go_i (wr_go),
    .rd_go_i (rd_go),
    .wr_ptr_o(wr_ptr),
    .rd_ptr_o(rd_ptr),
    .empty_o (empty),
    .full_o  (full)
  );

  strobe_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i,
    .we_i   (wr_go),
    .waddr_i(wr_ptr[ADDR_W-1:0]),
    .wdata_i(data_i),
    .raddr_i(rd_ptr[ADDR_W-1:0]),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_state_q <= RD_IDLE;
      dout_q     <= '0;
    end else if (rd_go) begin
      rd_state_q <= RD_SHOW;
      dout_q     <= rd_data;
    end else if (rd_ni) begin
      rd_state_q <= RD_IDLE;
    end
  end

  assign oe_o     = (rd_state_q == RD_SHOW);
  assign data_o   = oe_o ? dout_q : '0;
  assign empty_no = ~empty;
  assign full_no  = ~full;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_ni,
  input logic              rd_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              oe_o,
  input logic              empty_no,
  input logic              full_no,
  input logic [ADDR_W:0]   wr_ptr,
  input logic [ADDR_W:0]   rd_ptr
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W + 1)'(1) << ADDR_W;

  logic [ADDR_W:0] fill;
  assign fill = wr_ptr - rd_ptr;

  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= CAP);

  a_r11_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_no || full_no);

  a_r2_wr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wr_ptr) |-> (!$past(wr_ni) && wr_ptr == $past(wr_ptr) + 1'b1));

  a_r4_oe_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> $past(rd_ni));

  a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && $past(oe_o)) |-> $stable(data_o));

  a_r5_no_show_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(empty_no));

  a_r8_rptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(oe_o) && !$past(rd_ni)) |-> $stable(rd_ptr));
endmodule

bind strobe_fifo strobe_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_ni   (wr_ni),
  .rd_ni   (rd_ni),
  .data_o  (data_o),
  .oe_o    (oe_o),
  .empty_no(empty_no),
  .full_no (full_no),
  .wr_ptr  (wr_ptr),
  .rd_ptr  (rd_ptr)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
  localparam int DW = 9;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni, wr_ni, rd_ni;
  logic [DW-1:0] data_i, data_o;
  logic          oe_o, empty_no, full_no;
  int            n_cmp = 0;
  int            n_bad = 0;

  strobe_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_strobe_fifo (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // All tasks start and end just after a falling clock edge.
  task automatic wr_word(input logic [DW-1:0] d);
    data_i = d; wr_ni = 1'b0;
    @(negedge clk_i); wr_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic rd_word(input logic [DW-1:0] exp, input string req);
    rd_ni = 1'b0;
    @(negedge clk_i);
    chk({req, " oe"}, 32'(oe_o), 32'd1);
    chk({req, " data"}, 32'(data_o), 32'(exp));
    rd_ni = 1'b1;
    @(negedge clk_i);
    chk({req, " oe off"}, 32'(oe_o), 32'd0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; wr_ni = 1'b1; rd_ni = 1'b1; data_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 empty in reset", 32'(empty_no), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 empty", 32'(empty_no), 32'd0);
    chk("R1 full", 32'(full_no), 32'd1);
    chk("R1 oe", 32'(oe_o), 32'd0);
  endtask

  task automatic t_basic();
    wr_word(9'h0A1);
    chk("R2 not empty", 32'(empty_no), 32'd1);
    wr_word(9'h1B2);
    wr_word(9'h0C3);
    rd_word(9'h0A1, "R4/R6 first");
    rd_word(9'h1B2, "R6 second");
    rd_word(9'h0C3, "R6 third");
    chk("R6 empty after drain", 32'(empty_no), 32'd0);
  endtask

  task automatic t_empty_read();
    rd_ni = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R5 no oe while empty", 32'(oe_o), 32'd0);
    end
    rd_ni = 1'b1;
    @(negedge clk_i);
    wr_word(9'h055);
    chk("R5 released read ignored", 32'(oe_o), 32'd0);
    rd_word(9'h055, "R5 later read");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk("R11 not full below cap", 32'(full_no), 32'd1);
      wr_word(DW'(9'h010 + i));
    end
    chk("R11 full at cap", 32'(full_no), 32'd0);
    wr_word(9'h1EE);
    chk("R3 still full", 32'(full_no), 32'd0);
    // write flow-through
    data_i = 9'h155; wr_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 held write blocked", 32'(full_no), 32'd0);
    rd_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 read oe", 32'(oe_o), 32'd1);
    chk("R10 read data", 32'(data_o), 32'h010);
    chk("R10 full pulse", 32'(full_no), 32'd1);
    @(negedge clk_i);
    chk("R10 full again", 32'(full_no), 32'd0);
    rd_ni = 1'b1; wr_ni = 1'b1;
    @(negedge clk_i);
    chk("R4 oe off", 32'(oe_o), 32'd0);
    for (int i = 1; i < DEPTH; i++) rd_word(DW'(9'h010 + i), "R6/R3 drain");
    rd_word(9'h155, "R10 held word last");
    chk("R3 nothing extra", 32'(empty_no), 32'd0);
  endtask

  task automatic t_flow_read();
    rd_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    data_i = 9'h0F0; wr_ni = 1'b0;
    @(negedge clk_i);
    chk("R7 empty pulse", 32'(empty_no), 32'd1);
    chk("R7 oe not yet", 32'(oe_o), 32'd0);
    wr_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 oe", 32'(oe_o), 32'd1);
    chk("R7 data", 32'(data_o), 32'h0F0);
    chk("R7 empty back", 32'(empty_no), 32'd0);
    wr_word(9'h10F);
    chk("R8 write clears empty", 32'(empty_no), 32'd1);
    chk("R8 data held", 32'(data_o), 32'h0F0);
    wr_word(9'h133);
    chk("R8 data still held", 32'(data_o), 32'h0F0);
    chk("R8 oe held", 32'(oe_o), 32'd1);
    rd_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 oe off", 32'(oe_o), 32'd0);
    rd_word(9'h10F, "R9 next word");
    rd_word(9'h133, "R9 last word");
    chk("R9 empty", 32'(empty_no), 32'd0);
  endtask

  initial begin
    #(200_000 * 10);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_empty_read();
    t_full();
    t_flow_read();
    summary();
    $finish;
  end
endmodule